// File: doc/BRIEF.md
# Dual-Clock Shared Word Store with Port A Output Preset

A two-port synchronous memory of 2048 words by 16 bits for a small processor. Port A and port B each have their own clock, enable, write strobe, address, write data and read data. They can run on clocks that have no relation to each other. Both ports give their read data one clock after the access. On a write, the port's read output shows the newly written word.

Port A has a synchronous, active-low output preset. When it is applied, port A's read register loads the constant 0x8000. Every location holds 0x8000 from power-up until it is first written. A processor can therefore treat a fresh memory, or a preset read port, as returning a known non-zero pattern.

Internally the store is split into two banks, each written by one port only. A word is recovered by XOR-ing the two banks at the same address. This gives each bank a single writer and a single clock domain.

Top module: `tdp_preset_ram`

## Requirements
- R1: The memory has 2048 locations of 16 bits and 11-bit addresses on each port. The lowest address (0) and the highest address (2047) are both usable, and each port is timed only by its own clock.
- R2: A write on either port (enable high and write strobe high at that port's rising clock edge) stores the data. Either port then reads the stored word back.
- R3: While a port's enable is low at its clock edge, that port writes nothing and its read output keeps its previous value, whatever its write strobe, address and data are.
- R4: The ports are write-first. After an enabled write edge that is not under preset, the port's read output equals the data just written.
- R5: After an enabled non-write edge that is not under preset, the port's read output equals the word stored at the address, one clock after the access.
- R6: When a_rst_ni is low at an enabled port A edge, a_rdata_o becomes 0x8000. This overrides both a read and the write-first value.
- R7: A write on port A while a_rst_ni is low still updates the addressed location.
- R8: A location that has never been written reads 0x8000 on either port.
- R9: a_rst_ni has no effect at a port A edge where a_en_i is low: a_rdata_o holds.
- R10: Concurrent accesses by the two ports to different addresses are independent, and every write persists. Same-address writes from both ports in overlapping cycles give an undefined stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_clk_i | input | 1 | Port A clock |
| a_en_i | input | 1 | Port A enable |
| a_we_i | input | 1 | Port A write strobe |
| a_rst_ni | input | 1 | Port A synchronous output preset, active low |
| a_addr_i | input | 11 | Port A word address |
| a_wdata_i | input | 16 | Port A write data |
| a_rdata_o | output | 16 | Port A read data |
| b_clk_i | input | 1 | Port B clock |
| b_en_i | input | 1 | Port B enable |
| b_we_i | input | 1 | Port B write strobe |
| b_addr_i | input | 11 | Port B word address |
| b_wdata_i | input | 16 | Port B write data |
| b_rdata_o | output | 16 | Port B read data |

## Verification
The hardest situation to reach is two unrelated clocks writing and reading at the same time. Each word then depends on both banks being updated from the other side's current contents.

The bench runs the two ports in parallel on clocks of 10 ns and 13 ns, so their edges slide past each other. Port A uses only even addresses and port B only odd ones, which keeps the pair collision-free. A final sweep reads back across ports, so words written by one side are checked through the other.

Directed cases cover a write under preset, a preset with the enable low, and writes with the enable low, which are observed by reading the address back.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  localparam int unsigned ADDR_W     = 11;
  localparam int unsigned DATA_W     = 16;
  localparam logic [15:0] RESET_WORD = 16'h8000;
endpackage

// File: rtl/tdp_bank.sv
// Single-writer bank; two combinational read taps for the XOR recombination.
module tdp_bank #(
  parameter int unsigned AW   = 11,
  parameter int unsigned DW   = 16,
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_own_i,
  input  logic [AW-1:0] raddr_peer_i,
  output logic [DW-1:0] rown_o,
  output logic [DW-1:0] rpeer_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] = INIT;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rown_o  = mem_q[raddr_own_i];
  assign rpeer_o = mem_q[raddr_peer_i];

  logic armed_q = 1'b0;
  always_ff @(posedge clk_i) armed_q <= 1'b1;

  assert_store_R2: assert property (@(posedge clk_i) disable iff (!armed_q)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i))
    else $error("bank write not stored");
endmodule

// File: rtl/tdp_port.sv
// Per-port control: bank write encoding and the registered read output.
module tdp_port #(
  parameter int unsigned AW       = 11,
  parameter int unsigned DW       = 16,
  parameter bit          HAS_RST  = 1'b0,
  parameter logic [DW-1:0] RST_WORD = '0
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] own_word_i,
  input  logic [DW-1:0] peer_word_i,
  output logic          bank_we_o,
  output logic [DW-1:0] bank_wdata_o,
  output logic [DW-1:0] rdata_o
);
  logic          rst_hit;
  logic [DW-1:0] rdata_q = RST_WORD;

  assign rst_hit      = HAS_RST ? !rst_ni : 1'b0;
  assign bank_we_o    = en_i & we_i;
  // Own bank holds data ^ peer so that own ^ peer reproduces the data.
  assign bank_wdata_o = wdata_i ^ peer_word_i;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (rst_hit)   rdata_q <= RST_WORD;
      else if (we_i) rdata_q <= wdata_i;
      else           rdata_q <= own_word_i ^ peer_word_i;
    end
  end

  assign rdata_o = rdata_q;

  logic armed_q = 1'b0;
  always_ff @(posedge clk_i) armed_q <= 1'b1;

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!armed_q)
    !en_i |=> $stable(rdata_o))
    else $error("read output moved while disabled");

  assert_write_first_R4: assert property (@(posedge clk_i) disable iff (!armed_q)
    (en_i && we_i && !rst_hit) |=> rdata_o == $past(wdata_i))
    else $error("write-first data missing");

  generate
    if (HAS_RST) begin : g_rst_chk
      assert_preset_R6: assert property (@(posedge clk_i) disable iff (!armed_q)
        (en_i && !rst_ni) |=> rdata_o == RST_WORD)
        else $error("preset value not loaded");
    end
  endgenerate
endmodule

// File: rtl/tdp_preset_ram.sv
module tdp_preset_ram
  import tdp_pkg::*;
#(
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned DW       = DATA_W,
  parameter logic [DW-1:0] RST_WORD = RESET_WORD
) (
  input  logic          a_clk_i,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic          a_rst_ni,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_clk_i,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic          a_bank_we, b_bank_we;
  logic [DW-1:0] a_bank_wd, b_bank_wd;
  logic [DW-1:0] bank_a_at_a, bank_a_at_b, bank_b_at_b, bank_b_at_a;

  // Bank A carries the preset pattern; bank B starts at zero so A ^ B = RST_WORD.
  tdp_bank #(.AW(AW), .DW(DW), .INIT(RST_WORD)) u_bank_a (
    .clk_i(a_clk_i), .we_i(a_bank_we), .waddr_i(a_addr_i), .wdata_i(a_bank_wd),
    .raddr_own_i(a_addr_i), .raddr_peer_i(b_addr_i),
    .rown_o(bank_a_at_a), .rpeer_o(bank_a_at_b)
  );

  tdp_bank #(.AW(AW), .DW(DW), .INIT('0)) u_bank_b (
    .clk_i(b_clk_i), .we_i(b_bank_we), .waddr_i(b_addr_i), .wdata_i(b_bank_wd),
    .raddr_own_i(b_addr_i), .raddr_peer_i(a_addr_i),
    .rown_o(bank_b_at_b), .rpeer_o(bank_b_at_a)
  );

  tdp_port #(.AW(AW), .DW(DW), .HAS_RST(1'b1), .RST_WORD(RST_WORD)) u_port_a (
    .clk_i(a_clk_i), .en_i(a_en_i), .we_i(a_we_i), .rst_ni(a_rst_ni),
    .wdata_i(a_wdata_i), .own_word_i(bank_a_at_a), .peer_word_i(bank_b_at_a),
    .bank_we_o(a_bank_we), .bank_wdata_o(a_bank_wd), .rdata_o(a_rdata_o)
  );

  tdp_port #(.AW(AW), .DW(DW), .HAS_RST(1'b0), .RST_WORD(RST_WORD)) u_port_b (
    .clk_i(b_clk_i), .en_i(b_en_i), .we_i(b_we_i), .rst_ni(1'b1),
    .wdata_i(b_wdata_i), .own_word_i(bank_b_at_b), .peer_word_i(bank_a_at_b),
    .bank_we_o(b_bank_we), .bank_wdata_o(b_bank_wd), .rdata_o(b_rdata_o)
  );
endmodule

// File: tb/tb_tdp_preset_ram.sv
`timescale 1ns/1ps
module tb_tdp_preset_ram;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam logic [15:0] PRESET = 16'h8000;

  logic          a_clk_i = 0, b_clk_i = 0;
  logic          a_en_i = 0, a_we_i = 0, a_rst_ni = 1;
  logic [AW-1:0] a_addr_i = '0;
  logic [DW-1:0] a_wdata_i = '0;
  logic [DW-1:0] a_rdata_o;
  logic          b_en_i = 0, b_we_i = 0;
  logic [AW-1:0] b_addr_i = '0;
  logic [DW-1:0] b_wdata_i = '0;
  logic [DW-1:0] b_rdata_o;

  always #5   a_clk_i = ~a_clk_i;
  always #6.5 b_clk_i = ~b_clk_i;

  tdp_preset_ram dut (
    .a_clk_i(a_clk_i), .a_en_i(a_en_i), .a_we_i(a_we_i), .a_rst_ni(a_rst_ni),
    .a_addr_i(a_addr_i), .a_wdata_i(a_wdata_i), .a_rdata_o(a_rdata_o),
    .b_clk_i(b_clk_i), .b_en_i(b_en_i), .b_we_i(b_we_i),
    .b_addr_i(b_addr_i), .b_wdata_i(b_wdata_i), .b_rdata_o(b_rdata_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] model [1 << AW];

  function automatic logic [DW-1:0] expect_word(input logic [DW-1:0] prev, input bit en,
      input bit we, input bit rst_n, input logic [DW-1:0] wd, input logic [DW-1:0] stored);
    if (!en)        return prev;
    else if (!rst_n) return PRESET;
    else if (we)    return wd;
    else            return stored;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_do(input string req, input bit en, input bit we, input bit rst_n,
                      input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    logic [DW-1:0] prev, exp;
    @(negedge a_clk_i);
    prev = a_rdata_o;
    exp  = expect_word(prev, en, we, rst_n, wd, model[addr]);
    a_en_i = en; a_we_i = we; a_rst_ni = rst_n; a_addr_i = addr; a_wdata_i = wd;
    @(posedge a_clk_i);
    #1;
    if (en && we) model[addr] = wd;
    check(req, a_rdata_o, exp);
    a_en_i = 0; a_we_i = 0; a_rst_ni = 1;
  endtask

  task automatic b_do(input string req, input bit en, input bit we,
                      input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    logic [DW-1:0] prev, exp;
    @(negedge b_clk_i);
    prev = b_rdata_o;
    exp  = expect_word(prev, en, we, 1'b1, wd, model[addr]);
    b_en_i = en; b_we_i = we; b_addr_i = addr; b_wdata_i = wd;
    @(posedge b_clk_i);
    #1;
    if (en && we) model[addr] = wd;
    check(req, b_rdata_o, exp);
    b_en_i = 0; b_we_i = 0;
  endtask

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7321);
    for (int i = 0; i < (1 << AW); i++) model[i] = PRESET;

    // Reset state of port A read register
    a_do("R6", 1, 0, 0, 11'd3, 16'h0000);
    // Fresh locations, both ends of the address range
    a_do("R8", 1, 0, 1, 11'd5, 16'h0000);
    b_do("R8", 1, 0, 11'd2047, 16'h0000);
    // Write-first and cross-port read
    a_do("R4", 1, 1, 1, 11'd10, 16'h1234);
    b_do("R2", 1, 0, 11'd10, 16'h0000);
    b_do("R4", 1, 1, 11'd20, 16'hBEEF);
    a_do("R2", 1, 0, 1, 11'd20, 16'h0000);
    // Boundary addresses
    a_do("R1", 1, 1, 1, 11'd0, 16'hA5A5);
    b_do("R1", 1, 1, 11'd2047, 16'h5A5A);
    a_do("R1", 1, 0, 1, 11'd2047, 16'h0000);
    b_do("R1", 1, 0, 11'd0, 16'h0000);
    // Disabled write: output holds, memory untouched
    a_do("R3", 0, 1, 1, 11'd11, 16'hDEAD);
    b_do("R3", 1, 0, 11'd11, 16'h0000);
    b_do("R3", 0, 1, 11'd12, 16'hCAFE);
    a_do("R3", 1, 0, 1, 11'd12, 16'h0000);
    // Write under preset: output preset, memory updated
    a_do("R6", 1, 1, 0, 11'd13, 16'h7777);
    b_do("R7", 1, 0, 11'd13, 16'h0000);
    a_do("R5", 1, 0, 1, 11'd13, 16'h0000);
    // Preset ignored while disabled
    a_do("R9", 0, 0, 0, 11'd13, 16'h0000);
    // Preset overrides a read of a written word
    a_do("R6", 1, 0, 0, 11'd10, 16'h0000);

    // Concurrent random traffic; A on even, B on odd addresses
    fork
      for (int i = 0; i < 400; i++) begin
        logic [AW-1:0] ad;
        ad = {$urandom_range(0, 1023)}[AW-1:0] << 1;
        a_do(($urandom_range(0, 1) != 0) ? "R10" : "R5", $urandom_range(0, 7) != 0,
             $urandom_range(0, 1) != 0, $urandom_range(0, 15) != 0, ad, 16'($urandom));
      end
      for (int i = 0; i < 400; i++) begin
        logic [AW-1:0] ad;
        ad = ({$urandom_range(0, 1023)}[AW-1:0] << 1) | 11'd1;
        b_do(($urandom_range(0, 1) != 0) ? "R10" : "R5", $urandom_range(0, 7) != 0,
             $urandom_range(0, 1) != 0, ad, 16'($urandom));
      end
    join

    // Cross-port sweep
    for (int i = 0; i < 96; i++) begin
      a_do("R10", 1, 0, 1, 11'($urandom_range(0, 2047)), 16'h0000);
      b_do("R10", 1, 0, 11'($urandom_range(0, 2047)), 16'h0000);
    end

    done = 1;
    finish_run();
  end
endmodule